// File: doc/BRIEF.md
# DMA Channel Run Control

This block sequences one DMA channel that moves data as transfers, each made of one read cycle followed by one write cycle. A 2-bit run code, written by the host, selects one of four actions: clear the channel, stop at the next cycle boundary, stop at the next transfer boundary, or run. A 2-bit status output reports where the channel is held. The status is one of three cases: between transfers, between the read and the write of a transfer, or active.

Toward memory the block drives two request/acknowledge handshakes, one for reads and one for writes. The datum returned by a read is kept in a holding register and sent out with the following write. A transfer counter is loaded by the host and decremented by each completed write. When the counter reaches zero, the block stops by itself and flags completion.

Top module: `dma_run_ctl`

## Requirements
- R1: While rst_ni is low, run_code_o is 00, status_o is 00, rd_req_o, wr_req_o and done_o are 0, and xfer_cnt_o is 0.
- R2: A write to the run code (run_we_i) becomes visible on run_code_o after the next clock edge. A write issued at the same edge as an automatic code change takes priority over it.
- R3: With run code 11 and a nonzero count at a transfer boundary, the channel issues a read. Each read datum is then written out by the following write, so the written data sequence equals the read data sequence.
- R4: A request stays high until its acknowledge is seen at a clock edge. rd_req_o and wr_req_o are never high together.
- R5: Each completed write decrements xfer_cnt_o. After the write that brings it to zero, done_o is high for exactly one cycle, run_code_o becomes 10, status_o is 00, and no further read is issued.
- R6: Run code 01 written while a read is outstanding lets that read complete and then holds with status_o = 01 and no write issued. A later code 11 issues only the pending write, which carries the held datum, and no extra read.
- R7: Run code 01 written while a write is outstanding lets that write complete and then holds with status_o = 00 and no new read. A later code 11 resumes with the next transfer.
- R8: Run code 10 written while a read is outstanding still completes that transfer's write, then holds with status_o = 00.
- R9: Run code 00 clears xfer_cnt_o at the edge it is written. An outstanding read still completes, but its datum is discarded and no write follows. A datum held between read and write is cancelled. The next run starts with a read.
- R10: status_o is 01 only while held between read and write under run code 01. It is 11 while run code is 11 or a request is outstanding, and 00 otherwise. It is never 10.
- R11: Run code 11 with xfer_cnt_o at zero at a transfer boundary issues no cycle and no done pulse, and run_code_o changes to 10 one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_we_i | input | 1 | Run code write strobe |
| run_code_i | input | 2 | Run code to write (00 clear, 01 cycle halt, 10 transfer halt, 11 run) |
| cnt_we_i | input | 1 | Transfer count load strobe |
| cnt_i | input | CW | Transfer count to load |
| run_code_o | output | 2 | Current run code |
| status_o | output | 2 | Hold status (00 boundary, 01 mid-transfer, 11 active) |
| xfer_cnt_o | output | CW | Remaining transfer count |
| done_o | output | 1 | One-cycle pulse when the count expires |
| rd_req_o | output | 1 | Read request |
| rd_ack_i | input | 1 | Read acknowledge, data valid with it |
| rd_data_i | input | DW | Read data |
| wr_req_o | output | 1 | Write request |
| wr_ack_i | input | 1 | Write acknowledge |
| wr_data_o | output | DW | Write data from the holding register |

## Verification
The delicate coincidence is a halt-at-cycle-boundary write landing in the same cycle as a read acknowledge. The bench takes manual control of the acknowledges and raises rd_ack_i on the same cycle as run_we_i carrying 01. Because the new code only counts from the following edge, the read is judged as completed under run. The bench therefore expects the write to be issued with the just-read datum and status 11. After the write acknowledge, it expects a hold at status 00 with no new read and the count one lower. Around this, sweeps over counts 1 to 6 and acknowledge latencies 0 to 2 compare write data, read and write totals and done pulses against arithmetic expectations.

// File: rtl/dma_rc_pkg.sv
package dma_rc_pkg;
  typedef enum logic [1:0] {
    CODE_CLEAR     = 2'b00,
    CODE_HALT_CYC  = 2'b01,
    CODE_HALT_XFER = 2'b10,
    CODE_RUN       = 2'b11
  } run_code_e;

  typedef enum logic [1:0] {
    PH_BND = 2'b00,
    PH_RD  = 2'b01,
    PH_MID = 2'b10,
    PH_WR  = 2'b11
  } phase_e;

  localparam logic [1:0] ST_BND = 2'b00;
  localparam logic [1:0] ST_MID = 2'b01;
  localparam logic [1:0] ST_ACT = 2'b11;
endpackage

// File: rtl/dma_rc_cmd.sv
module dma_rc_cmd
  import dma_rc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      we_i,
  input  run_code_e code_i,
  input  logic      auto_halt_i,
  output run_code_e code_o
);
  run_code_e code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          code_q <= CODE_CLEAR;
    else if (we_i)        code_q <= code_i;
    else if (auto_halt_i) code_q <= CODE_HALT_XFER;
  end

  assign code_o = code_q;

  // R2
  host_write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> code_q == $past(code_i));
endmodule

// File: rtl/dma_rc_cnt.sv
module dma_rc_cnt #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o,
  output logic          last_o
);
  localparam logic [CW-1:0] ONE = CW'(1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)    cnt_q <= cnt_q - ONE;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
  assign last_o = (cnt_q == ONE);

  // R9
  clear_to_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  // R5
  no_count_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !clr_i) |=> cnt_q <= $past(cnt_q));
endmodule

// File: rtl/dma_rc_seq.sv
module dma_rc_seq
  import dma_rc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  run_code_e     code_i,
  input  logic          cnt_zero_i,
  input  logic          cnt_last_i,
  output logic          rd_req_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_req_o,
  input  logic          wr_ack_i,
  output logic [DW-1:0] wr_data_o,
  output logic          dec_o,
  output logic          auto_halt_o,
  output logic          done_o,
  output logic [1:0]    status_o
);
  phase_e        ph_q, ph_d;
  logic          drop_q;
  logic          done_q, done_d;
  logic          hold_en;
  logic [DW-1:0] hold_q;
  logic          discard;

  // a read begun before a clear stays marked for discard even if run returns
  assign discard = drop_q || (code_i == CODE_CLEAR);

  always_comb begin
    ph_d        = ph_q;
    dec_o       = 1'b0;
    done_d      = 1'b0;
    auto_halt_o = 1'b0;
    hold_en     = 1'b0;
    unique case (ph_q)
      PH_BND: begin
        if (code_i == CODE_RUN) begin
          if (cnt_zero_i) auto_halt_o = 1'b1;
          else            ph_d = PH_RD;
        end
      end
      PH_RD: begin
        if (rd_ack_i) begin
          if (discard) ph_d = PH_BND;
          else begin
            hold_en = 1'b1;
            ph_d    = (code_i == CODE_HALT_CYC) ? PH_MID : PH_WR;
          end
        end
      end
      PH_MID: begin
        unique case (code_i)
          CODE_CLEAR:               ph_d = PH_BND;
          CODE_RUN, CODE_HALT_XFER: ph_d = PH_WR;
          default:                  ph_d = PH_MID;
        endcase
      end
      PH_WR: begin
        if (wr_ack_i) begin
          dec_o = 1'b1;
          if (cnt_last_i) begin
            auto_halt_o = 1'b1;
            done_d      = 1'b1;
            ph_d        = PH_BND;
          end else if (code_i == CODE_RUN) ph_d = PH_RD;
          else                             ph_d = PH_BND;
        end
      end
      default: ph_d = PH_BND;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_BND;
      drop_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      done_q <= done_d;
      if (ph_q == PH_RD && rd_ack_i)                   drop_q <= 1'b0;
      else if (ph_q == PH_RD && code_i == CODE_CLEAR)  drop_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hold_q <= '0;
    else if (hold_en) hold_q <= rd_data_i;
  end

  assign rd_req_o  = (ph_q == PH_RD);
  assign wr_req_o  = (ph_q == PH_WR);
  assign wr_data_o = hold_q;
  assign done_o    = done_q;

  always_comb begin
    if (ph_q == PH_MID && code_i == CODE_HALT_CYC)          status_o = ST_MID;
    else if (code_i == CODE_RUN || rd_req_o || wr_req_o)    status_o = ST_ACT;
    else                                                    status_o = ST_BND;
  end

  // R4
  rd_req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o);
  // R4
  wr_req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_ack_i |=> wr_req_o);
  // R4
  one_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_req_o, wr_req_o}));
  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  mid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o == ST_MID && code_i == CODE_HALT_CYC |=> !wr_req_o);
  // R9
  drop_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_ack_i && code_i == CODE_CLEAR |=> !wr_req_o);
endmodule

// File: rtl/dma_run_ctl.sv
module dma_run_ctl
  import dma_rc_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_we_i,
  input  logic [1:0]    run_code_i,
  input  logic          cnt_we_i,
  input  logic [CW-1:0] cnt_i,
  output logic [1:0]    run_code_o,
  output logic [1:0]    status_o,
  output logic [CW-1:0] xfer_cnt_o,
  output logic          done_o,
  output logic          rd_req_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_req_o,
  input  logic          wr_ack_i,
  output logic [DW-1:0] wr_data_o
);
  run_code_e code;
  logic      cnt_zero, cnt_last, dec, auto_halt, cnt_clr;

  assign cnt_clr = run_we_i && (run_code_i == 2'b00);

  dma_rc_cmd u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (run_we_i),
    .code_i      (run_code_e'(run_code_i)),
    .auto_halt_i (auto_halt),
    .code_o      (code)
  );

  dma_rc_cnt #(.CW(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (cnt_clr),
    .load_i     (cnt_we_i),
    .load_val_i (cnt_i),
    .dec_i      (dec),
    .cnt_o      (xfer_cnt_o),
    .zero_o     (cnt_zero),
    .last_o     (cnt_last)
  );

  dma_rc_seq #(.DW(DW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .code_i      (code),
    .cnt_zero_i  (cnt_zero),
    .cnt_last_i  (cnt_last),
    .rd_req_o    (rd_req_o),
    .rd_ack_i    (rd_ack_i),
    .rd_data_i   (rd_data_i),
    .wr_req_o    (wr_req_o),
    .wr_ack_i    (wr_ack_i),
    .wr_data_o   (wr_data_o),
    .dec_o       (dec),
    .auto_halt_o (auto_halt),
    .done_o      (done_o),
    .status_o    (status_o)
  );

  assign run_code_o = code;

  // R5
  done_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !$past(run_we_i) |-> run_code_o == 2'b10 && xfer_cnt_o == '0);
endmodule

// File: tb/dma_run_ctl_tb.sv
`timescale 1ns/1ps
module dma_run_ctl_tb;
  localparam int DW = 8;
  localparam int CW = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic run_we_i = 1'b0;
  logic [1:0] run_code_i = 2'b00;
  logic cnt_we_i = 1'b0;
  logic [CW-1:0] cnt_i = '0;
  logic [1:0] run_code_o, status_o;
  logic [CW-1:0] xfer_cnt_o;
  logic done_o, rd_req_o, wr_req_o;
  logic rd_ack_i, wr_ack_i;
  logic [DW-1:0] rd_data_i = '0;
  logic [DW-1:0] wr_data_o;

  logic mem_rd_ack = 1'b0, mem_wr_ack = 1'b0;
  logic man_rd_ack = 1'b0, man_wr_ack = 1'b0;
  assign rd_ack_i = mem_rd_ack | man_rd_ack;
  assign wr_ack_i = mem_wr_ack | man_wr_ack;

  int checks = 0, errors = 0;
  int lat = 0, rd_wt = 0, wr_wt = 0;
  bit manual = 0, rd_stall = 0, wr_stall = 0;
  int rd_n = 0, wr_n = 0, done_n = 0, done_wide = 0, rd_seq = 0;
  bit done_prev = 0;
  logic [DW-1:0] rd_log [0:15];
  logic [DW-1:0] wr_log [0:15];

  always #4 clk_i = ~clk_i;

  dma_run_ctl #(.DW(DW), .CW(CW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_we_i(run_we_i), .run_code_i(run_code_i),
    .cnt_we_i(cnt_we_i), .cnt_i(cnt_i), .run_code_o(run_code_o), .status_o(status_o),
    .xfer_cnt_o(xfer_cnt_o), .done_o(done_o), .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .wr_req_o(wr_req_o), .wr_ack_i(wr_ack_i), .wr_data_o(wr_data_o)
  );

  // behavioural memory and monitor, acting between rising edges
  always @(negedge clk_i) begin
    if (done_o) begin
      done_n++;
      if (done_prev) done_wide++;
    end
    done_prev = done_o;
    if (mem_rd_ack) mem_rd_ack = 1'b0;
    else if (rd_req_o && !rd_stall && !manual) begin
      if (rd_wt >= lat) begin
        rd_data_i = DW'(8'h30 + rd_seq);
        rd_log[rd_n & 15] = rd_data_i;
        rd_n++; rd_seq++; rd_wt = 0;
        mem_rd_ack = 1'b1;
      end else rd_wt++;
    end
    if (mem_wr_ack) mem_wr_ack = 1'b0;
    else if (wr_req_o && !wr_stall && !manual) begin
      if (wr_wt >= lat) begin
        wr_log[wr_n & 15] = wr_data_o;
        wr_n++; wr_wt = 0;
        mem_wr_ack = 1'b1;
      end else wr_wt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_logs();
    rd_n = 0; wr_n = 0; done_n = 0; done_wide = 0;
  endtask

  task automatic put_code(input logic [1:0] c);
    @(negedge clk_i); run_we_i = 1'b1; run_code_i = c;
    @(negedge clk_i); run_we_i = 1'b0;
  endtask

  task automatic put_cnt(input int n);
    @(negedge clk_i); cnt_we_i = 1'b1; cnt_i = CW'(n);
    @(negedge clk_i); cnt_we_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic wait_rd();
    for (int i = 0; i < 100 && !rd_req_o; i++) @(negedge clk_i);
  endtask

  task automatic wait_wr();
    for (int i = 0; i < 100 && !wr_req_o; i++) @(negedge clk_i);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 400 && done_n == 0; i++) @(negedge clk_i);
    idle(2);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit ok;
    logic [DW-1:0] held;
    // R1 reset state
    idle(3);
    chk(run_code_o == 2'b00 && status_o == 2'b00, "R1 code/status", {run_code_o, status_o}, 0);
    chk(!rd_req_o && !wr_req_o && !done_o && xfer_cnt_o == 0, "R1 outputs", xfer_cnt_o, 0);
    rst_ni = 1'b1;
    idle(2);

    // R11 run with zero count
    clr_logs();
    put_code(2'b11);
    idle(1);
    chk(run_code_o == 2'b10, "R11 code after empty run", run_code_o, 2);
    chk(rd_n == 0 && !rd_req_o && done_n == 0, "R11 no cycle", rd_n, 0);

    // R3 R5 R10 sweep over count and latency
    for (int n = 1; n <= 6; n++) begin
      for (int l = 0; l <= 2; l++) begin
        lat = l; clr_logs();
        put_cnt(n);
        put_code(2'b11);
        chk(status_o == 2'b11, "R10 active status", status_o, 3);
        wait_done();
        chk(wr_n == n && rd_n == n, "R3 write count", wr_n, n);
        ok = 1;
        for (int i = 0; i < n; i++) if (wr_log[i] != rd_log[i]) ok = 0;
        chk(ok, "R3 data order", wr_log[0], rd_log[0]);
        chk(xfer_cnt_o == 0 && done_n == 1 && done_wide == 0, "R5 done pulse", done_n, 1);
        chk(run_code_o == 2'b10 && status_o == 2'b00, "R5 code/status", {run_code_o, status_o}, 8);
        idle(3);
        chk(!rd_req_o && rd_n == n, "R5 no extra read", rd_n, n);
      end
    end
    lat = 0;

    // R6 halt on cycle boundary during read, then resume
    clr_logs(); rd_stall = 1;
    put_cnt(3); put_code(2'b11); wait_rd();
    put_code(2'b01);
    rd_stall = 0; idle(4);
    chk(status_o == 2'b01, "R6 mid status", status_o, 1);
    chk(wr_n == 0 && !wr_req_o && rd_n == 1, "R6 no write", wr_n, 0);
    held = rd_log[0];
    put_code(2'b11); wait_done();
    chk(wr_log[0] == held, "R6 held datum", wr_log[0], held);
    chk(rd_n == 3 && wr_n == 3, "R6 no extra read", rd_n, 3);

    // R7 halt on cycle boundary during write
    clr_logs(); wr_stall = 1;
    put_cnt(4); put_code(2'b11); wait_wr();
    put_code(2'b01);
    wr_stall = 0; idle(4);
    chk(status_o == 2'b00 && !rd_req_o, "R7 boundary hold", status_o, 0);
    chk(wr_n == 1 && rd_n == 1 && xfer_cnt_o == 3, "R7 one transfer", xfer_cnt_o, 3);
    put_code(2'b11); wait_done();
    chk(wr_n == 4 && rd_n == 4, "R7 resume total", wr_n, 4);

    // R8 halt on transfer boundary during read
    clr_logs(); rd_stall = 1;
    put_cnt(2); put_code(2'b11); wait_rd();
    put_code(2'b10);
    rd_stall = 0; idle(5);
    chk(wr_n == 1 && status_o == 2'b00 && xfer_cnt_o == 1, "R8 transfer finished", wr_n, 1);
    chk(run_code_o == 2'b10 && !rd_req_o, "R8 held", run_code_o, 2);

    // R9 clear during outstanding read
    clr_logs(); rd_stall = 1;
    put_cnt(3); put_code(2'b11); wait_rd();
    put_code(2'b00);
    chk(xfer_cnt_o == 0, "R9 count cleared", xfer_cnt_o, 0);
    rd_stall = 0; idle(5);
    chk(rd_n == 1 && wr_n == 0 && status_o == 2'b00, "R9 read discarded", wr_n, 0);
    put_cnt(2); put_code(2'b11); wait_done();
    chk(wr_n == 2 && wr_log[0] == rd_log[1] && wr_log[1] == rd_log[2], "R9 fresh start", wr_log[0], rd_log[1]);

    // R9 clear cancels datum held mid-transfer
    clr_logs(); rd_stall = 1;
    put_cnt(1); put_code(2'b11); wait_rd();
    put_code(2'b01); rd_stall = 0; idle(3);
    put_code(2'b00); idle(2);
    chk(status_o == 2'b00 && wr_n == 0 && !wr_req_o, "R9 mid cancelled", status_o, 0);
    put_cnt(1); put_code(2'b11); wait_done();
    chk(rd_n == 2 && wr_n == 1 && wr_log[0] == rd_log[1], "R9 restart reads", rd_n, 2);

    // R2 R7 halt written in the same cycle as the read acknowledge
    clr_logs(); manual = 1;
    put_cnt(2); put_code(2'b11);
    @(negedge clk_i);
    chk(rd_req_o, "R3 read issued", rd_req_o, 1);
    rd_data_i = 8'h5A; man_rd_ack = 1; run_we_i = 1; run_code_i = 2'b01;
    @(negedge clk_i); man_rd_ack = 0; run_we_i = 0;
    chk(wr_req_o && status_o == 2'b11 && wr_data_o == 8'h5A, "R2 ack wins over halt", wr_data_o, 8'h5A);
    man_wr_ack = 1;
    @(negedge clk_i); man_wr_ack = 0;
    chk(status_o == 2'b00 && !wr_req_o && !rd_req_o && xfer_cnt_o == 1, "R7 hold after write", xfer_cnt_o, 1);
    idle(3);
    chk(!rd_req_o && run_code_o == 2'b01, "R7 stays held", run_code_o, 1);
    manual = 0;
    put_code(2'b00);

    finish_run();
  end
endmodule